// File: doc/BRIEF.md
# Defective Pixel Median Repair Filter

This block hides bad samples read back from a reference frame store that is known to hold faulty cells. Every incoming beat carries one 8-bit component value (luma or chroma), the eight values of the same component that surround it in the same frame, and a flag taken from a defect map built earlier. When the flag is clear, the stored value is forwarded unchanged. When the flag is set, the stored value is discarded. The eight surrounding values are ordered by magnitude, and the output is the rounded mean of the 4th and 5th smallest.

Both sides use a valid/ready handshake. Every beat passes through the same fixed three-stage pipeline, whether or not it is repaired. Results therefore leave in the order the beats arrived. A stalled consumer freezes the whole pipeline without dropping or duplicating data.

Top module: `defect_median_fix`

## Requirements
- R1: When the defect flag of a beat is 0, the output value equals that beat's centre value.
- R2: When the defect flag is 1, the output is computed only from the eight neighbour values; the centre value has no effect on it.
- R3: For a flagged beat, with a and b the 4th and 5th smallest neighbours, the output is (a + b + 1) >> 1 computed on 9 bits, so a half rounds up (3 and 4 give 4).
- R4: A flagged beat whose eight neighbours are all equal produces that same value.
- R5: A flagged beat with four neighbours at 0 and four at 255 produces 128.
- R6: The result for a flagged beat does not depend on which neighbour lane holds which value (neighbour i occupies bits 8i+7 to 8i of `in_nbrs`).
- R7: With `out_ready` held high, a beat accepted at clock edge k appears on the output after edge k+2. Results leave in acceptance order.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_pix` and `out_valid` hold their values. Once the pipeline is full, `in_ready` is 0, and no beat is lost.
- R9: A synchronous active-high reset empties the pipeline, so after it `out_valid` is 0 and `in_ready` is 1.
- R10: A beat is taken only on an edge where `in_valid` and `in_ready` are both 1. Data presented with `in_valid` at 0 produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat is valid |
| in_ready | output | 1 | Block can accept a beat |
| in_defect | input | 1 | Defect-map flag for the centre location |
| in_centre | input | 8 | Stored value at the centre location |
| in_nbrs | input | 64 | Eight neighbour values, lane i at bits 8i+7:8i |
| out_valid | output | 1 | Output value is valid |
| out_ready | input | 1 | Consumer accepts the output |
| out_pix | output | 8 | Forwarded or repaired value |

## Verification
The hardest case to reach is a pipeline that is full with the consumer stalled while a new beat waits at the input. There, the held output, the blocked input and the later drain must all line up with no beat lost or repeated. The stimulus reaches it by holding `out_ready` low while three beats are pushed in. It then releases the stall and checks the drained values in order. Long random phases with an irregular `out_ready` repeat the situation many times. Neighbour sets drawn from narrow value ranges produce ties across the middle ranks, and directed sets cover the rounding and extreme-value cases.

// File: rtl/pix_fix_pkg.sv
package pix_fix_pkg;

    localparam int PIX_W  = 8;
    localparam int NBR    = 8;
    localparam int MID_LO = NBR / 2 - 1;
    localparam int MID_HI = NBR / 2;

    typedef logic [PIX_W-1:0] pix_t;

    // beat as captured from the input handshake
    typedef struct packed {
        logic                 defect;
        pix_t                 centre;
        logic [NBR-1:0][PIX_W-1:0] nbr;
    } beat_t;

    // beat after the middle ranks have been found
    typedef struct packed {
        logic defect;
        pix_t centre;
        pix_t lo;
        pix_t hi;
    } mid_t;

    // rounded mean, half rounds up, using one extra bit for the sum
    function automatic pix_t mean_up(pix_t a, pix_t b);
        logic [PIX_W:0] s;
        s = {1'b0, a} + {1'b0, b} + {{PIX_W{1'b0}}, 1'b1};
        return PIX_W'(s >> 1);
    endfunction

endpackage

// File: rtl/oe_layer.sv
module oe_layer #(
    parameter int N     = 8,
    parameter int PIX_W = 8,
    parameter int ODD   = 0
) (
    input  logic [N-1:0][PIX_W-1:0] d,
    output logic [N-1:0][PIX_W-1:0] q
);
    // one layer of an odd-even transposition network
    always_comb begin
        q = d;
        for (int i = ODD; i + 1 < N; i += 2) begin
            if (d[i] > d[i+1]) begin
                q[i]   = d[i+1];
                q[i+1] = d[i];
            end
        end
    end
endmodule

// File: rtl/mid_sorter.sv
module mid_sorter #(
    parameter int N     = 8,
    parameter int PIX_W = 8
) (
    input  logic [N-1:0][PIX_W-1:0] d,
    output logic [PIX_W-1:0]        lo,
    output logic [PIX_W-1:0]        hi
);
    localparam int LAYERS = N;
    localparam int RLO    = N / 2 - 1;
    localparam int RHI    = N / 2;

    logic [N-1:0][PIX_W-1:0] w [0:LAYERS];

    assign w[0] = d;

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        oe_layer #(
            .N     (N),
            .PIX_W (PIX_W),
            .ODD   (l % 2)
        ) u_layer (
            .d (w[l]),
            .q (w[l+1])
        );
    end

    assign lo = w[LAYERS][RLO];
    assign hi = w[LAYERS][RHI];
endmodule

// File: rtl/defect_median_fix.sv
module defect_median_fix
    import pix_fix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_defect,
    input  logic [PIX_W-1:0]     in_centre,
    input  logic [NBR*PIX_W-1:0] in_nbrs,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PIX_W-1:0]     out_pix
);
    logic  en;
    beat_t a_q;
    logic  a_valid;
    mid_t  b_q;
    logic  b_valid;
    pix_t  c_pix;
    logic  c_valid;
    pix_t  s_lo, s_hi;

    // whole pipeline advances unless the last stage is blocked
    assign en       = !c_valid || out_ready;
    assign in_ready = en;

    // stage A: capture
    always_ff @(posedge clk) begin
        if (rst)     a_valid <= 1'b0;
        else if (en) a_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (en && in_valid) begin
            a_q.defect <= in_defect;
            a_q.centre <= in_centre;
            a_q.nbr    <= in_nbrs;
        end
    end

    mid_sorter #(
        .N     (NBR),
        .PIX_W (PIX_W)
    ) u_sort (
        .d  (a_q.nbr),
        .lo (s_lo),
        .hi (s_hi)
    );

    // stage B: middle ranks
    always_ff @(posedge clk) begin
        if (rst)     b_valid <= 1'b0;
        else if (en) b_valid <= a_valid;
    end

    always_ff @(posedge clk) begin
        if (en) begin
            b_q.defect <= a_q.defect;
            b_q.centre <= a_q.centre;
            b_q.lo     <= s_lo;
            b_q.hi     <= s_hi;
        end
    end

    // stage C: select and output
    always_ff @(posedge clk) begin
        if (rst)     c_valid <= 1'b0;
        else if (en) c_valid <= b_valid;
    end

    always_ff @(posedge clk) begin
        if (en) c_pix <= b_q.defect ? mean_up(b_q.lo, b_q.hi) : b_q.centre;
    end

    assign out_valid = c_valid;
    assign out_pix   = c_pix;

    // R2: sorter hands over ranks in ascending order
    p_mid_order_r2: assert property (@(posedge clk) disable iff (rst)
        b_valid |-> (b_q.lo <= b_q.hi));

    // R3: repaired value lies between the two middle ranks
    p_mean_bounds_r3: assert property (@(posedge clk) disable iff (rst)
        (en && b_valid && b_q.defect) |=>
            (c_pix >= $past(b_q.lo) && c_pix <= $past(b_q.hi)));

    // R1: unflagged beats leave with their stored value
    p_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (en && b_valid && !b_q.defect) |=> (c_pix == $past(b_q.centre)));

    // R8: a blocked output holds still
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (c_valid && !out_ready) |=> (c_valid && $stable(c_pix)));
endmodule

// File: tb/sim_defect_median_fix.sv
module sim_defect_median_fix;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_defect = 1'b0;
    logic [7:0]  in_centre = '0;
    logic [63:0] in_nbrs = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_pix;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;       // 0 always ready, 1 random, 2 stalled
    bit done = 1'b0;
    string cur_tag = "R1";

    logic [7:0] exp_v [0:1023];
    string      exp_t [0:1023];
    int head = 0;
    int tail = 0;

    bit         hold_prev = 1'b0;
    logic [7:0] prev_pix = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    defect_median_fix u0 (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_defect (in_defect), .in_centre (in_centre), .in_nbrs (in_nbrs),
        .out_valid (out_valid), .out_ready (out_ready), .out_pix (out_pix)
    );

    function automatic logic [7:0] ref_out(logic d, logic [7:0] c, logic [63:0] n);
        logic [7:0] v [8];
        logic [7:0] t;
        logic [8:0] s;
        if (!d) return c;
        for (int i = 0; i < 8; i++) v[i] = n[8*i +: 8];
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 7 - i; j++)
                if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
        s = {1'b0, v[3]} + {1'b0, v[4]} + 9'd1;
        return s[8:1];
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // consumer readiness, changed just after each rising edge
    initial forever begin
        @(posedge clk); #1;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom % 4) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (hold_prev) begin
                check(out_valid && out_pix == prev_pix, "R8 hold", int'(out_pix), int'(prev_pix));
            end
            if (in_valid && in_ready) begin
                exp_v[tail % 1024] = ref_out(in_defect, in_centre, in_nbrs);
                exp_t[tail % 1024] = cur_tag;
                tail++;
            end
            if (out_valid && out_ready) begin
                if (head == tail) check(1'b0, "R10 extra output", int'(out_pix), -1);
                else begin
                    check(out_pix == exp_v[head % 1024], exp_t[head % 1024],
                          int'(out_pix), int'(exp_v[head % 1024]));
                    head++;
                end
            end
            hold_prev = out_valid && !out_ready;
            prev_pix  = out_pix;
        end
    end

    // call at rising edge + 1; returns at rising edge + 1 after acceptance
    task automatic send(logic d, logic [7:0] c, logic [63:0] n, string tag);
        in_valid = 1'b1; in_defect = d; in_centre = c; in_nbrs = n; cur_tag = tag;
        forever begin
            @(negedge clk);
            if (in_ready) begin @(posedge clk); #1; break; end
            @(posedge clk); #1;
        end
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    function automatic logic [63:0] rnd_nbrs();
        logic [63:0] n;
        int base = $urandom % 256;
        int span = ($urandom % 2) ? 256 : 4;
        for (int i = 0; i < 8; i++) n[8*i +: 8] = 8'((base + ($urandom % span)) % 256);
        return n;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int lat;
        bit seen;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9: empty after reset
        check(!out_valid && in_ready, "R9 reset", int'({out_valid, in_ready}), 1);
        @(posedge clk); #1;

        // R10: data without valid is never taken
        in_valid = 1'b0; in_defect = 1'b1; in_centre = 8'd77; in_nbrs = '1;
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (out_valid) seen = 1'b1; end
        check(!seen, "R10 no transfer", int'(seen), 0);
        @(posedge clk); #1;

        // R7: latency
        send(1'b0, 8'd42, 64'h0, "R1");
        idle(0);
        lat = 1;
        forever begin
            @(negedge clk);
            if (out_valid || lat > 10) break;
            lat++;
            @(posedge clk);
        end
        check(lat == 3, "R7 latency", lat, 3);
        @(posedge clk); #1;
        idle(4);

        // directed corners
        send(1'b1, 8'd255, {8{8'd10}}, "R2 centre ignored");
        send(1'b1, 8'd0,   {8{8'd10}}, "R2 centre ignored");
        send(1'b1, 8'd5,   {8{8'd200}}, "R4 equal");
        send(1'b1, 8'd9,   {{4{8'd255}}, {4{8'd0}}}, "R5 extremes");
        send(1'b1, 8'd9,   {8'd0, 8'd255, 8'd0, 8'd255, 8'd255, 8'd0, 8'd255, 8'd0}, "R5 extremes");
        send(1'b1, 8'd1,   {8'd9, 8'd9, 8'd9, 8'd4, 8'd3, 8'd0, 8'd0, 8'd0}, "R3 round");
        send(1'b1, 8'd1,   {8'd4, 8'd0, 8'd9, 8'd0, 8'd9, 8'd3, 8'd0, 8'd9}, "R6 permute");
        send(1'b1, 8'd1,   {8'd0, 8'd9, 8'd3, 8'd9, 8'd0, 8'd4, 8'd9, 8'd0}, "R6 permute");
        send(1'b0, 8'd255, {8{8'd3}}, "R1");
        send(1'b0, 8'd0,   {8{8'd250}}, "R1");
        idle(6);

        // R8: full pipeline with stalled consumer
        rdy_mode = 2;
        @(posedge clk); #1;
        send(1'b1, 8'd7, {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8}, "R8 drain");
        send(1'b0, 8'd66, 64'h0, "R8 drain");
        send(1'b1, 8'd0, {8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1}, "R8 drain");
        in_valid = 1'b1; in_defect = 1'b0; in_centre = 8'd99; cur_tag = "R8 drain";
        repeat (5) @(negedge clk);
        check(!in_ready, "R8 input blocked", int'(in_ready), 0);
        rdy_mode = 0;
        forever begin
            @(negedge clk);
            if (in_ready) begin @(posedge clk); #1; break; end
        end
        idle(6);

        // random traffic with irregular stalls
        rdy_mode = 1;
        for (int k = 0; k < 400; k++) begin
            logic d = ($urandom % 2) == 0;
            send(d, 8'($urandom), rnd_nbrs(), d ? "R2 random" : "R1 random");
            if (($urandom % 5) == 0) idle(1 + $urandom % 3);
        end
        idle(1);
        rdy_mode = 0;
        for (int i = 0; i < 50 && head != tail; i++) @(posedge clk);
        check(head == tail, "R7 all drained", tail - head, 0);
        finish_run();
    end
endmodule